// File: doc/BRIEF.md
# Multi-Port Memory March Self-Test Sequencer

This block drives a built-in self-test of a synchronous memory array that is reached through four ports. After a start request it walks a fixed list of six March elements over the whole address space, with some elements counting the address up and some counting it down. Every write goes out on port 1 alone. Every read goes out on all four ports in the same cycle, and each port's returned data is compared one cycle later against the expected all-zeros or all-ones 18-bit word.

A read cycle in which any port returns a wrong word adds one to a fail tally. At the end of the sequence a single-cycle done pulse marks the point at which the result word is final. Bit 0 of the result is a pass/fail flag and the upper bits hold the saturating tally, ready to be shifted out by an external test port. The memory array and the serial shifting logic are outside the block.

Top module: `mbist_march_ctrl`

## Requirements
- R1: A synchronous reset returns the sequencer to idle. While idle after reset, no read or write enable is high, done_o is low and result_o is zero.
- R2: When start_i is high at a clock edge while the block is idle, operations begin in the next cycle, one operation per cycle. All ports carry the same address, and the elements run in this order: write 0 (up); read 0, write 1, read 1 (up); read 1, write 0, read 0 (up); read 0, write 1, read 1 (down); read 1, write 0, read 0 (down); read 0 (up). Up runs from 0 to 2^ADDR_W-1, down runs from 2^ADDR_W-1 to 0, and all steps of an element are done at one address before the next address.
- R3: In a write operation only port 1 (index 0) writes. port_wr_o is high, every bit of port_rd_o is low, and port_wdata_o is all ones for a 1 and all zeros for a 0.
- R4: In a read operation every bit of port_rd_o is high and port_wr_o is low.
- R5: Read data is compared in the cycle after the read is issued. A read cycle fails if any port's 18-bit word differs from the expected pattern, and a failing cycle adds exactly 1 to the tally however many ports mismatch.
- R6: result_o[0] is 1 when the tally is nonzero and 0 otherwise. result_o[RES_W-1:1] holds the tally, which stops at its all-ones value.
- R7: done_o is high for exactly one cycle, N+1 clock edges after the edge that accepted start, where N = 14*2^ADDR_W is the number of operations. result_o is final while done_o is high and holds until the next accepted start.
- R8: start_i has no effect while a sequence is running. The operation stream goes on unchanged.
- R9: An accepted start clears the tally of the previous run, so result_o reads zero in the first operation cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to run the test sequence |
| port_addr_o | output | NPORTS*ADDR_W | Address of port p in bits [p*ADDR_W +: ADDR_W] |
| port_rd_o | output | NPORTS | Read enable, one bit per port |
| port_wr_o | output | 1 | Write enable of port 1 |
| port_wdata_o | output | DATA_W | Write data of port 1 |
| port_rdata_i | input | NPORTS*DATA_W | Read data of port p in bits [p*DATA_W +: DATA_W], valid the cycle after the read |
| done_o | output | 1 | One-cycle end-of-test pulse |
| result_o | output | RES_W | {fail tally, nonzero flag} |

## Verification
The bench injects faults at address 0, at the top address and in the middle. It uses faults that corrupt reads of ones, faults that corrupt reads of zeros, and lost writes, so each fault fails a different known share of the nine reads per address. A sequencer that turned an element around at the wrong end, or walked a down element upward, would shift the operation stream and give the wrong tally. One fault corrupts all four ports at the same cell. A design that counted mismatching ports instead of cycles would report four times the expected tally. A fully broken port drives a narrow-tally instance past its limit, where a missing saturation would wrap around. The bench also pulses start in mid-run, which a restarting design would show as a broken operation stream. Finally it compares the done cycle with the run length, which a design that compared read data in the issue cycle would miss by one.

// File: rtl/mbist_march_pkg.sv
package mbist_march_pkg;

  localparam int NUM_ELEMS = 6;
  localparam int ELEM_W    = 3;
  localparam int STEP_W    = 2;

  typedef enum logic {SEQ_IDLE, SEQ_RUN} seq_state_e;

  typedef struct packed {
    logic is_wr;
    logic val;
  } march_op_t;

  // index of the last step inside element e (elements have one or three steps)
  function automatic logic [STEP_W-1:0] elem_last_step(input logic [ELEM_W-1:0] e);
    case (e)
      3'd1, 3'd2, 3'd3, 3'd4: return 2'd2;
      default:                return 2'd0;
    endcase
  endfunction

  function automatic logic elem_is_down(input logic [ELEM_W-1:0] e);
    return (e == 3'd3) || (e == 3'd4);
  endfunction

  function automatic march_op_t elem_op(input logic [ELEM_W-1:0] e,
                                        input logic [STEP_W-1:0] k);
    march_op_t op;
    op.is_wr = 1'b0;
    op.val   = 1'b0;
    case (e)
      3'd0: op.is_wr = 1'b1;
      3'd1, 3'd3: begin
        op.is_wr = (k == 2'd1);
        op.val   = (k != 2'd0);
      end
      3'd2, 3'd4: begin
        op.is_wr = (k == 2'd1);
        op.val   = (k == 2'd0);
      end
      default: op.val = 1'b0;
    endcase
    return op;
  endfunction

endpackage

// File: rtl/march_seq.sv
module march_seq
  import mbist_march_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              hold_i,
  output logic              busy_o,
  output logic              accept_o,
  output logic              issue_o,
  output march_op_t         op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              final_o
);

  localparam logic [ELEM_W-1:0] LAST_ELEM = ELEM_W'(NUM_ELEMS - 1);
  localparam logic [ADDR_W-1:0] ADDR_TOP  = '1;

  function automatic logic [ADDR_W-1:0] first_addr(input logic [ELEM_W-1:0] e);
    return elem_is_down(e) ? ADDR_TOP : '0;
  endfunction

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                  input logic down);
    return down ? a - 1'b1 : a + 1'b1;
  endfunction

  seq_state_e        state_q;
  logic [ELEM_W-1:0] elem_q;
  logic [STEP_W-1:0] step_q;
  logic [ADDR_W-1:0] addr_q;

  logic step_done;
  logic addr_end;
  logic down;

  always_comb begin
    busy_o    = (state_q == SEQ_RUN);
    accept_o  = start_i && !busy_o && !hold_i;
    down      = elem_is_down(elem_q);
    step_done = (step_q == elem_last_step(elem_q));
    addr_end  = down ? (addr_q == '0) : (addr_q == ADDR_TOP);
    issue_o   = busy_o;
    op_o      = elem_op(elem_q, step_q);
    addr_o    = addr_q;
    final_o   = busy_o && step_done && addr_end && (elem_q == LAST_ELEM);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      elem_q  <= '0;
      step_q  <= '0;
      addr_q  <= '0;
    end else if (accept_o) begin
      state_q <= SEQ_RUN;
      elem_q  <= '0;
      step_q  <= '0;
      addr_q  <= first_addr('0);
    end else if (busy_o) begin
      if (!step_done) begin
        step_q <= step_q + 1'b1;
      end else begin
        step_q <= '0;
        if (!addr_end) begin
          addr_q <= step_addr(addr_q, down);
        end else if (elem_q == LAST_ELEM) begin
          state_q <= SEQ_IDLE;
        end else begin
          elem_q <= elem_q + 1'b1;
          addr_q <= first_addr(elem_q + 1'b1);
        end
      end
    end
  end

endmodule

// File: rtl/march_port_drive.sv
module march_port_drive
  import mbist_march_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 18,
  parameter int NPORTS = 4
) (
  input  logic                     issue_i,
  input  march_op_t                op_i,
  input  logic [ADDR_W-1:0]        addr_i,
  output logic [NPORTS*ADDR_W-1:0] port_addr_o,
  output logic [NPORTS-1:0]        port_rd_o,
  output logic                     port_wr_o,
  output logic [DATA_W-1:0]        port_wdata_o
);

  logic rd_cycle;
  assign rd_cycle = issue_i && !op_i.is_wr;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    assign port_addr_o[p*ADDR_W +: ADDR_W] = addr_i;
    assign port_rd_o[p]                    = rd_cycle;
  end

  assign port_wr_o    = issue_i && op_i.is_wr;
  assign port_wdata_o = {DATA_W{op_i.val}};

endmodule

// File: rtl/march_read_check.sv
module march_read_check
  import mbist_march_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int NPORTS = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     issue_i,
  input  march_op_t                op_i,
  input  logic                     final_i,
  input  logic [NPORTS*DATA_W-1:0] rdata_i,
  output logic                     fail_o,
  output logic                     end_o,
  output logic                     pend_o
);

  function automatic logic [DATA_W-1:0] pattern(input logic v);
    return {DATA_W{v}};
  endfunction

  logic             vld_q;
  logic             exp_q;
  logic             end_q;
  logic [NPORTS-1:0] mism;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      exp_q <= 1'b0;
      end_q <= 1'b0;
    end else begin
      vld_q <= issue_i && !op_i.is_wr;
      exp_q <= op_i.val;
      end_q <= final_i;
    end
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_cmp
    assign mism[p] = rdata_i[p*DATA_W +: DATA_W] != pattern(exp_q);
  end

  assign fail_o = vld_q && (|mism);
  assign end_o  = end_q;
  assign pend_o = vld_q || end_q;

endmodule

// File: rtl/march_fail_tally.sv
module march_fail_tally #(
  parameter int RES_W = 25
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             fail_i,
  input  logic             end_i,
  output logic             done_o,
  output logic [RES_W-1:0] result_o
);

  localparam int CNT_W = RES_W - 1;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
    return (&c) ? c : c + 1'b1;
  endfunction

  logic [CNT_W-1:0] count_q;
  logic             done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= end_i;
      if (clear_i)     count_q <= '0;
      else if (fail_i) count_q <= sat_inc(count_q);
    end
  end

  assign done_o   = done_q;
  assign result_o = {count_q, |count_q};

endmodule

// File: rtl/mbist_march_ctrl.sv
module mbist_march_ctrl
  import mbist_march_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 18,
  parameter int NPORTS = 4,
  parameter int RES_W  = 25
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start_i,
  output logic [NPORTS*ADDR_W-1:0] port_addr_o,
  output logic [NPORTS-1:0]        port_rd_o,
  output logic                     port_wr_o,
  output logic [DATA_W-1:0]        port_wdata_o,
  input  logic [NPORTS*DATA_W-1:0] port_rdata_i,
  output logic                     done_o,
  output logic [RES_W-1:0]         result_o
);

  // named internal events, also watched by the bound checker
  logic              busy;
  logic              accept;
  logic              issue;
  march_op_t         op;
  logic [ADDR_W-1:0] addr;
  logic              final_op;
  logic              fail_evt;
  logic              chk_end;
  logic              chk_pend;

  march_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .hold_i   (chk_pend),
    .busy_o   (busy),
    .accept_o (accept),
    .issue_o  (issue),
    .op_o     (op),
    .addr_o   (addr),
    .final_o  (final_op)
  );

  march_port_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NPORTS(NPORTS)) u_drive (
    .issue_i      (issue),
    .op_i         (op),
    .addr_i       (addr),
    .port_addr_o  (port_addr_o),
    .port_rd_o    (port_rd_o),
    .port_wr_o    (port_wr_o),
    .port_wdata_o (port_wdata_o)
  );

  march_read_check #(.DATA_W(DATA_W), .NPORTS(NPORTS)) u_check (
    .clk     (clk),
    .rst     (rst),
    .issue_i (issue),
    .op_i    (op),
    .final_i (final_op),
    .rdata_i (port_rdata_i),
    .fail_o  (fail_evt),
    .end_o   (chk_end),
    .pend_o  (chk_pend)
  );

  march_fail_tally #(.RES_W(RES_W)) u_tally (
    .clk      (clk),
    .rst      (rst),
    .clear_i  (accept),
    .fail_i   (fail_evt),
    .end_i    (chk_end),
    .done_o   (done_o),
    .result_o (result_o)
  );

endmodule

// File: rtl/mbist_march_chk.sv
module mbist_march_chk #(
  parameter int NPORTS = 4,
  parameter int RES_W  = 25
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              busy,
  input logic              accept,
  input logic              fail_evt,
  input logic [NPORTS-1:0] port_rd_o,
  input logic              port_wr_o,
  input logic              done_o,
  input logic [RES_W-1:0]  result_o
);

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  always_ff @(posedge clk) begin
    if (rst_q) begin
      assert_reset_clear_R1: assert (result_o == '0 && !done_o && port_rd_o == '0 && !port_wr_o)
        else $error("outputs not cleared by reset");
    end
  end

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (port_rd_o == '0 && !port_wr_o));

  assert_rw_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    port_wr_o |-> port_rd_o == '0);

  assert_all_ports_read_R4: assert property (@(posedge clk) disable iff (rst)
    (|port_rd_o) |-> (&port_rd_o));

  assert_fail_adds_one_R5: assert property (@(posedge clk) disable iff (rst)
    (fail_evt && !accept && !(&result_o[RES_W-1:1]))
      |=> result_o[RES_W-1:1] == $past(result_o[RES_W-1:1]) + 1'b1);

  assert_pass_bit_R6: assert property (@(posedge clk) disable iff (rst)
    result_o[0] == (|result_o[RES_W-1:1]));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && start_i) |-> !accept);

endmodule

bind mbist_march_ctrl mbist_march_chk #(.NPORTS(NPORTS), .RES_W(RES_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start_i   (start_i),
  .busy      (busy),
  .accept    (accept),
  .fail_evt  (fail_evt),
  .port_rd_o (port_rd_o),
  .port_wr_o (port_wr_o),
  .done_o    (done_o),
  .result_o  (result_o)
);

// File: tb/test_mbist_march_ctrl.sv
module test_mem_model #(
  parameter int AW = 4,
  parameter int DW = 18,
  parameter int NP = 4
) (
  input  logic           clk,
  input  logic           wr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic [NP-1:0]  rd_i,
  input  logic [NP*AW-1:0] addr_i,
  output logic [NP*DW-1:0] rdata_o,
  input  int             f_mode,
  input  int             f_addr,
  input  int             f_port
);
  // fault modes: 0 none, 1 read bit0 stuck at 1 (one port, one cell),
  // 2 read bit0 stuck at 0 (one port, one cell), 3 writes to one cell lost,
  // 4 every read of one port inverted, 5 read bit5 stuck at 1 on all ports at one cell
  logic [DW-1:0] mem [1<<AW];

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
    rdata_o = '0;
  end

  always @(posedge clk) begin
    if (wr_i && !(f_mode == 3 && int'(addr_i[AW-1:0]) == f_addr))
      mem[addr_i[AW-1:0]] <= wdata_i;
    for (int p = 0; p < NP; p++) begin
      if (rd_i[p]) begin
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        a = addr_i[p*AW +: AW];
        d = mem[a];
        if (f_mode == 1 && int'(a) == f_addr && p == f_port) d[0] = 1'b1;
        if (f_mode == 2 && int'(a) == f_addr && p == f_port) d[0] = 1'b0;
        if (f_mode == 4 && p == f_port) d = ~d;
        if (f_mode == 5 && int'(a) == f_addr) d[5] = 1'b1;
        rdata_o[p*DW +: DW] <= d;
      end
    end
  end
endmodule

module test_mbist_march_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW     = 4;
  localparam int DW     = 18;
  localparam int NP     = 4;
  localparam int RW     = 25;
  localparam int SAT_RW = 4;
  localparam int DEPTH  = 1 << AW;
  localparam int N_OPS  = 14 * DEPTH;

  logic clk = 1'b0;
  logic rst;
  logic start_i;

  logic [NP*AW-1:0] port_addr, sat_addr;
  logic [NP-1:0]    port_rd, sat_rd;
  logic             port_wr, sat_wr;
  logic [DW-1:0]    port_wdata, sat_wdata;
  logic [NP*DW-1:0] port_rdata, sat_rdata;
  logic             done, sat_done;
  logic [RW-1:0]    result;
  logic [SAT_RW-1:0] sat_result;

  int f_mode = 0, f_addr = 0, f_port = 0;
  int n_checks = 0, n_fail = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbist_march_ctrl #(.ADDR_W(AW), .DATA_W(DW), .NPORTS(NP), .RES_W(RW)) i_mbist_march_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i),
    .port_addr_o(port_addr), .port_rd_o(port_rd), .port_wr_o(port_wr),
    .port_wdata_o(port_wdata), .port_rdata_i(port_rdata),
    .done_o(done), .result_o(result));

  test_mem_model #(.AW(AW), .DW(DW), .NP(NP)) i_mem (
    .clk(clk), .wr_i(port_wr), .wdata_i(port_wdata), .rd_i(port_rd),
    .addr_i(port_addr), .rdata_o(port_rdata),
    .f_mode(f_mode), .f_addr(f_addr), .f_port(f_port));

  // narrow-tally instance whose port 1 always reads inverted data
  mbist_march_ctrl #(.ADDR_W(AW), .DATA_W(DW), .NPORTS(NP), .RES_W(SAT_RW)) i_mbist_march_ctrl_sat (
    .clk(clk), .rst(rst), .start_i(start_i),
    .port_addr_o(sat_addr), .port_rd_o(sat_rd), .port_wr_o(sat_wr),
    .port_wdata_o(sat_wdata), .port_rdata_i(sat_rdata),
    .done_o(sat_done), .result_o(sat_result));

  test_mem_model #(.AW(AW), .DW(DW), .NP(NP)) i_mem_sat (
    .clk(clk), .wr_i(sat_wr), .wdata_i(sat_wdata), .rd_i(sat_rd),
    .addr_i(sat_addr), .rdata_o(sat_rdata),
    .f_mode(4), .f_addr(0), .f_port(0));

  function automatic longint exp_result(input longint cnt, input int width);
    longint cmax, c;
    cmax = (longint'(1) << (width - 1)) - 1;
    c = (cnt > cmax) ? cmax : cnt;
    return c * 2 + ((c != 0) ? 1 : 0);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected at most 100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  task automatic run_check(input int mode, input int faddr, input int fport,
                           input longint exp_cnt, input bit inject_start);
    int idx, err_addr, err_wr, err_rd;
    longint res_first;
    idx = 0; err_addr = 0; err_wr = 0; err_rd = 0; res_first = 0;
    @(negedge clk);
    f_mode = mode; f_addr = faddr; f_port = fport;
    start_i = 1'b1;
    @(posedge clk);
    for (int e = 0; e < 6; e++) begin
      int len;
      bit down;
      len  = (e == 0 || e == 5) ? 1 : 3;
      down = (e == 3 || e == 4);
      for (int i = 0; i < DEPTH; i++) begin
        int a;
        a = down ? DEPTH - 1 - i : i;
        for (int k = 0; k < len; k++) begin
          bit wr, val;
          wr  = (e == 0) || (len == 3 && k == 1);
          if (e == 1 || e == 3)      val = (k != 0);
          else if (e == 2 || e == 4) val = (k == 0);
          else                       val = 1'b0;
          @(negedge clk);
          start_i = inject_start && (idx == 40);
          if (idx == 0) res_first = longint'(result);
          for (int p = 0; p < NP; p++)
            if (int'(port_addr[p*AW +: AW]) != a) err_addr++;
          if (wr) begin
            if (!(port_wr && port_rd == '0 && port_wdata == {DW{val}})) err_wr++;
          end else begin
            if (!(port_rd == '1 && !port_wr)) err_rd++;
          end
          idx++;
          @(posedge clk);
        end
      end
    end
    check(res_first == 0, "R9", "tally cleared at start", res_first, 0);
    if (inject_start)
      check(err_addr == 0 && err_wr == 0 && err_rd == 0, "R8",
            "stream disturbed by start during run", err_addr + err_wr + err_rd, 0);
    else begin
      check(err_addr == 0, "R2", "address/order mismatches", err_addr, 0);
      check(err_wr == 0, "R3", "write op mismatches", err_wr, 0);
      check(err_rd == 0, "R4", "read op mismatches", err_rd, 0);
    end
    @(negedge clk);
    check(done == 1'b0, "R7", "done early at edge N", done, 0);
    @(posedge clk); @(negedge clk);
    check(done == 1'b1, "R7", "done at edge N+1", done, 1);
    check(longint'(result) == exp_result(exp_cnt, RW), "R5",
          "result word", longint'(result), exp_result(exp_cnt, RW));
    check(sat_done && longint'(sat_result) == exp_result(longint'(9 * DEPTH), SAT_RW), "R6",
          "saturated result", longint'(sat_result), exp_result(longint'(9 * DEPTH), SAT_RW));
    @(posedge clk); @(negedge clk);
    check(done == 1'b0 && longint'(result) == exp_result(exp_cnt, RW), "R7",
          "done not single or result not held", longint'(result), exp_result(exp_cnt, RW));
    f_mode = 0;
  endtask

  initial begin
    int bad;
    rst = 1'b1;
    start_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!done && result == '0 && port_rd == '0 && !port_wr, "R1",
          "reset state", longint'(result), 0);
    rst = 1'b0;
    repeat (2) @(posedge clk);

    run_check(0, 0, 0, 0, 1'b0);                   // clean array
    run_check(1, 5, 2, 5, 1'b0);                   // reads of 0 fail: 4 March + final
    run_check(2, 0, 3, 4, 1'b0);                   // reads of 1 fail, address 0
    run_check(3, DEPTH - 1, 0, 4, 1'b0);           // lost writes at top address
    run_check(5, 9, 0, 5, 1'b0);                   // all ports wrong: still one per cycle (R5)
    run_check(4, 0, 1, longint'(9 * DEPTH), 1'b0); // whole port inverted: every read
    run_check(0, 0, 0, 0, 1'b1);                   // start pulsed mid-run, tally cleared

    // synchronous reset in the middle of a run (R1)
    @(negedge clk);
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    repeat (37) @(posedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(!done && result == '0 && port_rd == '0 && !port_wr, "R1",
          "state after mid-run reset", longint'(result), 0);
    bad = 0;
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      if (done || port_rd != '0 || port_wr) bad++;
    end
    check(bad == 0, "R1", "activity after reset", bad, 0);

    run_check(0, 0, 0, 0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule